// File: doc/BRIEF.md
# Shared Bidirectional Barrel Shifter

This combinational unit produces every shift result needed by a small ALU from one left-shifting core. It handles logical shifts in both directions, arithmetic right shifts that replicate the sign bit, and arithmetic left shifts that report signed overflow. The operand and result are 8 bits wide and the shift distance is a 3-bit unsigned count from 0 to 7.

Right shifts are steered through the same core. A mirror stage reverses the bit order of the operand, the core shifts it left, and a second mirror stage restores normal bit order. For an arithmetic right shift, a fill mask that covers the vacated upper positions is ORed in when the operand's top bit is set. A zero flag reports an all-zero result. Opcode decoding, the adder path and any registers belong to the surrounding ALU.

Top module: `shift_unit`

## Requirements
- R1: With `kind_i` = 2'b00 (logical left), `result_o` equals the operand shifted left by `amt_i` places, with zeros entering at bit 0 and the bits shifted past bit 7 discarded.
- R2: With `kind_i` = 2'b01 (logical right), `result_o` equals the operand shifted right by `amt_i` places, with zeros entering at bit 7.
- R3: With `kind_i` = 2'b10 (arithmetic right), `result_o` equals the operand shifted right by `amt_i` places, and every vacated upper bit equals the operand's bit 7. This is the signed value divided by 2^amt and rounded toward minus infinity.
- R4: With `kind_i` = 2'b11 (arithmetic left), `result_o` has the same bits as the logical left shift, with zeros entering at bit 0.
- R5: With `kind_i` = 2'b11, `ovf_o` is 1 exactly when one of these bits differs from the operand's bit 7: a bit shifted out, or the new bit 7. This is the case when the signed product operand×2^amt lies outside -128..127.
- R6: `ovf_o` is 0 for `kind_i` values 2'b00, 2'b01 and 2'b10.
- R7: When `amt_i` is 0, `result_o` equals the operand and `ovf_o` is 0 for every value of `kind_i`.
- R8: `zero_o` is 1 exactly when all 8 bits of `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand to be shifted |
| amt_i | input | 3 | Unsigned shift distance, 0 to 7 |
| kind_i | input | 2 | Shift type: 00 logical left, 01 logical right, 10 arithmetic right, 11 arithmetic left |
| result_o | output | 8 | Shifted result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of an arithmetic left shift |

## Verification
The assertions check local properties on every input change. They confirm that a zero-distance shift is the identity, that only arithmetic left shifts can raise overflow, and that the zero flag agrees with the result. They also check that zeros fill the low bits on left shifts, that the top bit follows the sign on right shifts, and that the core never creates set bits. They cannot confirm that the mirrored core lands each bit in the correct position, or that the overflow rule matches signed range limits. The bench shows both by sweeping every operand, distance and type against values computed with multiplication, division and floor rounding.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ASL = 2'b11
  } shift_kind_e;

  function automatic logic kind_is_right(shift_kind_e k);
    return (k == SK_LSR) || (k == SK_ASR);
  endfunction

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign dout[i] = en ? din[WIDTH-1-i] : din[i];
  end

endmodule

// File: rtl/lshift_core.sv
module lshift_core #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [0:AMT_W];

  assign stg[0] = din;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][WIDTH-1-SH:0], {SH{1'b0}}} : stg[s];
  end

  assign dout = stg[AMT_W];

endmodule

// File: rtl/sign_fixup.sv
module sign_fixup #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic [AMT_W-1:0] amt,
  input  logic             arith_right,
  input  logic             arith_left,
  input  logic [WIDTH-1:0] shifted,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);

  // Ones in the top amt positions: the bits a right shift leaves empty.
  function automatic logic [WIDTH-1:0] upper_mask(logic [AMT_W-1:0] n);
    logic [WIDTH-1:0] m;
    for (int i = 0; i < WIDTH; i++) begin
      m[i] = (i >= WIDTH - int'(n));
    end
    return m;
  endfunction

  // Set when a bit leaving the top, or the new top bit, differs from the sign.
  function automatic logic left_overflow(logic [WIDTH-1:0] v, logic [AMT_W-1:0] n);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if ((i >= WIDTH - 1 - int'(n)) && (v[i] != v[WIDTH-1])) hit = 1'b1;
    end
    return hit;
  endfunction

  logic sign_fill;
  assign sign_fill = arith_right & opnd[WIDTH-1];

  always_comb begin
    result = shifted;
    if (sign_fill) result = shifted | upper_mask(amt);
    ovf = arith_left ? left_overflow(opnd, amt) : 1'b0;
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [1:0]       kind_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  import shift_pkg::*;

  shift_kind_e      kind;
  logic             rev_sel;
  logic [WIDTH-1:0] core_in;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] unmirrored;

  assign kind    = shift_kind_e'(kind_i);
  assign rev_sel = kind_is_right(kind);

  bit_mirror #(.WIDTH(WIDTH)) u_mirror_in (
    .en(rev_sel), .din(opnd_i), .dout(core_in)
  );

  lshift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_core (
    .din(core_in), .amt(amt_i), .dout(core_out)
  );

  bit_mirror #(.WIDTH(WIDTH)) u_mirror_out (
    .en(rev_sel), .din(core_out), .dout(unmirrored)
  );

  sign_fixup #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_fixup (
    .opnd(opnd_i),
    .amt(amt_i),
    .arith_right(kind == SK_ASR),
    .arith_left(kind == SK_ASL),
    .shifted(unmirrored),
    .result(result_o),
    .ovf(ovf_o)
  );

  assign zero_o = ~|result_o;

endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker #(
  parameter int WIDTH = 8,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic [AMT_W-1:0] amt_i,
  input logic [1:0]       kind_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             ovf_o,
  input logic [WIDTH-1:0] core_in,
  input logic [WIDTH-1:0] core_out
);

  always_comb begin
    // R7: zero distance is the identity and never overflows
    if (amt_i == '0) begin
      a_r7_amt_zero: assert (result_o == opnd_i && !ovf_o)
        else $error("a_r7_amt_zero");
    end
    // R6: only the arithmetic left type may flag overflow
    if (kind_i != 2'b11) begin
      a_r6_no_overflow: assert (!ovf_o) else $error("a_r6_no_overflow");
    end
    // R8: zero flag agrees with the result bits
    a_r8_zero_flag: assert (zero_o == (result_o == '0)) else $error("a_r8_zero_flag");
    // R1, R4: left shifts leave bit 0 clear after a nonzero distance
    if ((kind_i == 2'b00 || kind_i == 2'b11) && amt_i != '0) begin
      a_r4_low_fill: assert (!result_o[0]) else $error("a_r4_low_fill");
    end
    // R2: logical right clears the top bit after a nonzero distance
    if (kind_i == 2'b01 && amt_i != '0) begin
      a_r2_top_clear: assert (!result_o[WIDTH-1]) else $error("a_r2_top_clear");
    end
    // R3: arithmetic right keeps the sign in the top bit
    if (kind_i == 2'b10) begin
      a_r3_sign_kept: assert (result_o[WIDTH-1] == opnd_i[WIDTH-1])
        else $error("a_r3_sign_kept");
    end
    // R1: the shared core only discards bits, it never creates them
    a_r1_core_no_gain: assert ($countones(core_out) <= $countones(core_in))
      else $error("a_r1_core_no_gain");
  end

endmodule

bind shift_unit shift_unit_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_checker (
  .opnd_i(opnd_i),
  .amt_i(amt_i),
  .kind_i(kind_i),
  .result_o(result_o),
  .zero_o(zero_o),
  .ovf_o(ovf_o),
  .core_in(core_in),
  .core_out(core_out)
);

// File: tb/test_shift_unit.sv
module test_shift_unit;

  logic       clk = 1'b0;
  logic [7:0] opnd = '0;
  logic [2:0] amt = '0;
  logic [1:0] kind = '0;
  logic [7:0] result;
  logic       zero;
  logic       ovf;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  shift_unit i_shift_unit (
    .opnd_i(opnd), .amt_i(amt), .kind_i(kind),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  function automatic int signed_of(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int exp_result(int k, int a, int v);
    int d = 1 << a;
    int sv = signed_of(v);
    int r;
    case (k)
      0, 3: r = (v * d) % 256;
      1:    r = v / d;
      default: r = (sv >= 0) ? sv / d : -((-sv + d - 1) / d);
    endcase
    return r & 255;
  endfunction

  function automatic bit exp_ovf(int k, int a, int v);
    int p = signed_of(v) * (1 << a);
    return (k == 3) && (p > 127 || p < -128);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s opnd=%0d amt=%0d kind=%0d actual=%0d expected=%0d",
               tag, opnd, amt, kind, act, exp);
    end
  endtask

  initial begin
    string rtag;
    // Idle state: all-zero inputs give a zero result
    @(negedge clk);
    check("R8 idle zero flag", int'(zero), 1);
    check("R7 idle result", int'(result), 0);
    for (int k = 0; k < 4; k++) begin
      rtag = (k == 0) ? "R1" : (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
      for (int a = 0; a < 8; a++) begin
        for (int v = 0; v < 256; v++) begin
          @(posedge clk);
          opnd = 8'(v); amt = 3'(a); kind = 2'(k);
          @(negedge clk);
          check(rtag, int'(result), exp_result(k, a, v));
          check((k == 3) ? "R5" : "R6", int'(ovf), int'(exp_ovf(k, a, v)));
          check("R8", int'(zero), (exp_result(k, a, v) == 0) ? 1 : 0);
          if (a == 0) begin
            check("R7 identity", int'(result), v);
            check("R7 no overflow", int'(ovf), 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule